// File: doc/BRIEF.md
# Two-Port Shared Memory Arbiter

This block places one synchronous memory behind two requesting ports. Each port raises a request with an address, a write enable and write data. The block hands the memory to one port at a time. A request on an idle module is granted in the same cycle, and the module then stays busy for a fixed number of service cycles. A request that comes in while the module is busy is not queued. It waits on its own line until the module is free, or the requester drops it and raises it again later.

When both ports ask on the same idle cycle, the port that did not receive the previous grant wins. At the end of service a one-cycle done pulse goes back to the port that owns the access. For a read, the stored word is on the shared read-data output during that pulse.

Top module: `shmem_arb2`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, no grant is outstanding: `mem_busy`, `done_a` and `done_b` are 0 and no grant is given during reset. After reset the last-winner state is port B, so a tie on the first idle cycle goes to port A.
- R2: On an idle cycle (`mem_busy` = 0, not in reset), a request present on only one port raises that port's grant combinationally in the same cycle.
- R3: At most one grant is high in any cycle. No grant is given while `mem_busy` is 1.
- R4: After a grant, `mem_busy` is 1 for exactly `SVC_CYCLES` cycles (`SVC_CYCLES` ≥ 2), starting with the cycle after the grant. On the last of these cycles the granted port's done pulses for one cycle and the other port's done stays 0. On the cycle after that, `mem_busy` is 0.
- R5: A request that is held through a busy period is not granted during it. It is granted on the first idle cycle after the done pulse.
- R6: When both ports request on the same idle cycle, the grant goes to the port that did not win the most recent grant.
- R7: A granted write (`we` = 1) stores its write data at its address. A granted read (`we` = 0) presents the word last written to that address on `rd_data` in the cycle its done is high.
- R8: A request that is raised while the module is busy and dropped before the module becomes idle is never granted, and its write leaves memory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_a | input | 1 | Port A request level |
| we_a | input | 1 | Port A write enable (1 write, 0 read) |
| addr_a | input | ADDR_W | Port A word address |
| wdata_a | input | DATA_W | Port A write data |
| gnt_a | output | 1 | Port A grant, high on the idle cycle the access is accepted |
| done_a | output | 1 | Port A end-of-service pulse |
| req_b | input | 1 | Port B request level |
| we_b | input | 1 | Port B write enable (1 write, 0 read) |
| addr_b | input | ADDR_W | Port B word address |
| wdata_b | input | DATA_W | Port B write data |
| gnt_b | output | 1 | Port B grant, high on the idle cycle the access is accepted |
| done_b | output | 1 | Port B end-of-service pulse |
| rd_data | output | DATA_W | Read word, valid while the owning port's done is high |
| mem_busy | output | 1 | Module is serving an access |

## Verification
The bound checker watches the cycle-level rules on every cycle: grants are exclusive and never given while busy, a lone request is granted at once, a grant leads into a busy window whose length is counted, done goes only to the owner and ends the window, and ties follow the last winner. Only the bench scenarios can show that data round-trips through the memory. A full sweep writes every address from alternating ports and reads each one back from the opposite port. The scenarios also show that a held request is served next, and that a withdrawn write leaves its target word untouched.

// File: rtl/shmem_arb2_pkg.sv
package shmem_arb2_pkg;

  typedef enum logic {
    PORT_A = 1'b0,
    PORT_B = 1'b1
  } port_e;

  // Arbitration rule, returned as {pick_b, pick_a}.
  // A tie goes to the port that is not the last winner.
  function automatic logic [1:0] rr_pick(input logic ra, input logic rb, input port_e last);
    if (ra && rb) begin
      return (last == PORT_B) ? 2'b01 : 2'b10;
    end
    return {rb, ra};
  endfunction

endpackage

// File: rtl/shmem_arb2_pick.sv
module shmem_arb2_pick
  import shmem_arb2_pkg::*;
(
  input  logic  req_a,
  input  logic  req_b,
  input  logic  idle,
  input  port_e last,
  output logic  gnt_a,
  output logic  gnt_b
);

  logic [1:0] choice;

  assign choice = rr_pick(req_a, req_b, last);
  assign gnt_a  = idle && choice[0];
  assign gnt_b  = idle && choice[1];

endmodule

// File: rtl/shmem_arb2_seq.sv
module shmem_arb2_seq
  import shmem_arb2_pkg::*;
#(
  parameter int SVC_CYCLES = 3
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  start,
  input  port_e start_port,
  output logic  busy,
  output port_e owner,
  output logic  first_ph,
  output logic  last_ph
);

  localparam int CNT_W = (SVC_CYCLES > 1) ? $clog2(SVC_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SVC_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  // owner doubles as the last-winner record for the tie rule
  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt   <= '0;
      owner <= PORT_B;
    end else if (start) begin
      busy  <= 1'b1;
      cnt   <= '0;
      owner <= start_port;
    end else if (busy) begin
      if (last_ph) begin
        busy <= 1'b0;
      end
      cnt <= cnt + 1'b1;
    end
  end

  assign first_ph = busy && (cnt == '0);
  assign last_ph  = busy && (cnt == LAST_CNT);

endmodule

// File: rtl/shmem_arb2_ram.sv
module shmem_arb2_ram #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[addr] <= wdata;
    end
    if (rd_en) begin
      rdata <= mem[addr];
    end
  end

endmodule

// File: rtl/shmem_arb2.sv
module shmem_arb2
  import shmem_arb2_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 8,
  parameter int SVC_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_a,
  input  logic              we_a,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [DATA_W-1:0] wdata_a,
  output logic              gnt_a,
  output logic              done_a,
  input  logic              req_b,
  input  logic              we_b,
  input  logic [ADDR_W-1:0] addr_b,
  input  logic [DATA_W-1:0] wdata_b,
  output logic              gnt_b,
  output logic              done_b,
  output logic [DATA_W-1:0] rd_data,
  output logic              mem_busy
);

  // named internal events
  logic  busy;
  logic  idle;
  logic  svc_start;
  logic  first_ph;
  logic  svc_last;
  logic  pick_a;
  logic  pick_b;
  logic  ram_wr;
  logic  ram_rd;
  port_e owner;
  port_e start_port;

  // captured access
  logic              op_we;
  logic [ADDR_W-1:0] op_addr;
  logic [DATA_W-1:0] op_wdata;

  assign idle = !busy && !rst;

  shmem_arb2_pick u_pick (
    .req_a (req_a),
    .req_b (req_b),
    .idle  (idle),
    .last  (owner),
    .gnt_a (pick_a),
    .gnt_b (pick_b)
  );

  assign svc_start  = pick_a || pick_b;
  assign start_port = pick_b ? PORT_B : PORT_A;

  shmem_arb2_seq #(
    .SVC_CYCLES (SVC_CYCLES)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (svc_start),
    .start_port (start_port),
    .busy       (busy),
    .owner      (owner),
    .first_ph   (first_ph),
    .last_ph    (svc_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      op_we    <= 1'b0;
      op_addr  <= '0;
      op_wdata <= '0;
    end else if (svc_start) begin
      op_we    <= pick_b ? we_b    : we_a;
      op_addr  <= pick_b ? addr_b  : addr_a;
      op_wdata <= pick_b ? wdata_b : wdata_a;
    end
  end

  assign ram_wr = first_ph && op_we;
  assign ram_rd = first_ph && !op_we;

  shmem_arb2_ram #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_ram (
    .clk   (clk),
    .wr_en (ram_wr),
    .rd_en (ram_rd),
    .addr  (op_addr),
    .wdata (op_wdata),
    .rdata (rd_data)
  );

  assign gnt_a    = pick_a;
  assign gnt_b    = pick_b;
  assign done_a   = svc_last && (owner == PORT_A);
  assign done_b   = svc_last && (owner == PORT_B);
  assign mem_busy = busy;

endmodule

// File: rtl/shmem_arb2_chk.sv
module shmem_arb2_chk #(
  parameter int SVC_CYCLES = 3
) (
  input logic clk,
  input logic rst,
  input logic req_a,
  input logic req_b,
  input logic gnt_a,
  input logic gnt_b,
  input logic done_a,
  input logic done_b,
  input logic mem_busy,
  input logic svc_last
);

  logic [31:0] busy_run;
  logic        won_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_run <= '0;
      won_b    <= 1'b1;
    end else begin
      busy_run <= mem_busy ? busy_run + 1 : '0;
      if (gnt_b) begin
        won_b <= 1'b1;
      end else if (gnt_a) begin
        won_b <= 1'b0;
      end
    end
  end

  a_r3_one_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0({gnt_a, gnt_b}));

  a_r3_no_grant_busy: assert property (@(posedge clk) disable iff (rst)
    mem_busy |-> !(gnt_a || gnt_b));

  a_r2_lone_a: assert property (@(posedge clk) disable iff (rst)
    (!mem_busy && req_a && !req_b) |-> gnt_a);

  a_r2_lone_b: assert property (@(posedge clk) disable iff (rst)
    (!mem_busy && req_b && !req_a) |-> gnt_b);

  a_r4_grant_to_busy: assert property (@(posedge clk) disable iff (rst)
    (gnt_a || gnt_b) |=> mem_busy);

  a_r4_done_len: assert property (@(posedge clk) disable iff (rst)
    (done_a || done_b) |-> (mem_busy && busy_run == 32'(SVC_CYCLES - 1)));

  a_r4_hold_busy: assert property (@(posedge clk) disable iff (rst)
    (mem_busy && !(done_a || done_b)) |=> mem_busy);

  a_r4_release: assert property (@(posedge clk) disable iff (rst)
    (done_a || done_b) |=> !mem_busy);

  a_r4_done_owner_a: assert property (@(posedge clk) disable iff (rst)
    done_a |-> (!won_b && !done_b));

  a_r4_done_owner_b: assert property (@(posedge clk) disable iff (rst)
    done_b |-> (won_b && !done_a));

  a_r4_last_pulse: assert property (@(posedge clk) disable iff (rst)
    svc_last |-> (done_a != done_b));

  a_r6_tie: assert property (@(posedge clk) disable iff (rst)
    (!mem_busy && req_a && req_b) |-> (won_b ? gnt_a : gnt_b));

endmodule

bind shmem_arb2 shmem_arb2_chk #(
  .SVC_CYCLES (SVC_CYCLES)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_a    (req_a),
  .req_b    (req_b),
  .gnt_a    (gnt_a),
  .gnt_b    (gnt_b),
  .done_a   (done_a),
  .done_b   (done_b),
  .mem_busy (mem_busy),
  .svc_last (svc_last)
);

// File: tb/shmem_arb2_test.sv
`timescale 1ns/100ps
module shmem_arb2_test;

  localparam int AW  = 4;
  localparam int DW  = 8;
  localparam int SVC = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic          req_a = 1'b0, we_a = 1'b0, req_b = 1'b0, we_b = 1'b0;
  logic [AW-1:0] addr_a = '0, addr_b = '0;
  logic [DW-1:0] wdata_a = '0, wdata_b = '0;
  logic          gnt_a, gnt_b, done_a, done_b, mem_busy;
  logic [DW-1:0] rd_data;

  int checks = 0;
  int failures = 0;

  shmem_arb2 #(.ADDR_W(AW), .DATA_W(DW), .SVC_CYCLES(SVC)) uut (
    .clk(clk), .rst(rst),
    .req_a(req_a), .we_a(we_a), .addr_a(addr_a), .wdata_a(wdata_a),
    .gnt_a(gnt_a), .done_a(done_a),
    .req_b(req_b), .we_b(we_b), .addr_b(addr_b), .wdata_b(wdata_b),
    .gnt_b(gnt_b), .done_b(done_b),
    .rd_data(rd_data), .mem_busy(mem_busy)
  );

  function automatic logic [DW-1:0] pat(input int i);
    return DW'((i * 37 + 5) % 256);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_port(input bit pb, input bit r, input bit we,
                          input logic [AW-1:0] ad, input logic [DW-1:0] d);
    if (pb) begin
      req_b = r; we_b = we; addr_b = ad; wdata_b = d;
    end else begin
      req_a = r; we_a = we; addr_a = ad; wdata_a = d;
    end
  endtask

  task automatic expect_grant(input bit pb, input string tag);
    #0.5;
    chk({tag, " gnt_a"}, int'(gnt_a), int'(!pb));
    chk({tag, " gnt_b"}, int'(gnt_b), int'(pb));
  endtask

  // Follows one service window; other port request raised at on_k, dropped at off_k.
  task automatic serve(input bit pb, input bit is_rd, input logic [DW-1:0] exp,
                       input int on_k, input int off_k, input string tag);
    for (int k = 1; k <= SVC; k++) begin
      @(negedge clk);
      #0.5;
      if (k == 1) begin
        if (pb) req_b = 1'b0; else req_a = 1'b0;
      end
      if (k == on_k) begin
        if (pb) req_a = 1'b1; else req_b = 1'b1;
      end
      if (k == off_k) begin
        if (pb) req_a = 1'b0; else req_b = 1'b0;
      end
      #0.5;
      chk({tag, " R4 busy"}, int'(mem_busy), 1);
      chk({tag, " R3/R5 no grant while busy"}, int'(gnt_a | gnt_b), 0);
      chk({tag, " R4 owner done"}, int'(pb ? done_b : done_a), int'(k == SVC));
      chk({tag, " R4 other done"}, int'(pb ? done_a : done_b), 0);
      if (is_rd && k == SVC) begin
        chk({tag, " R7 read data"}, int'(rd_data), int'(exp));
      end
    end
    @(negedge clk);
    #1;
    chk({tag, " R4 released"}, int'(mem_busy), 0);
    chk({tag, " R4 done cleared"}, int'(done_a | done_b), 0);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog R4 actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    // R1: reset holds everything off even with both requesting
    set_port(0, 1, 1, 4'd0, 8'hA5);
    set_port(1, 1, 1, 4'd1, 8'h3C);
    repeat (3) @(negedge clk);
    #1;
    chk("R1 no grant in reset", int'(gnt_a | gnt_b), 0);
    chk("R1 idle in reset", int'(mem_busy), 0);
    chk("R1 no done in reset", int'(done_a | done_b), 0);
    rst = 1'b0;
    expect_grant(0, "R1 R6 first tie to A");
    serve(0, 0, '0, 0, 0, "R1 A write");
    expect_grant(1, "R5 held B");
    serve(1, 0, '0, 0, 0, "B write");

    // R6: tie after B won -> A
    set_port(0, 1, 0, 4'd1, '0);
    set_port(1, 1, 0, 4'd0, '0);
    expect_grant(0, "R6 tie after B");
    serve(0, 1, 8'h3C, 0, 0, "R7 A read 1");
    expect_grant(1, "R5 held B read");
    serve(1, 1, 8'hA5, 0, 0, "R7 B read 0");

    // R2 lone A, then R6 tie after A -> B
    set_port(0, 1, 0, 4'd0, '0);
    expect_grant(0, "R2 lone A");
    serve(0, 1, 8'hA5, 0, 0, "R2 A read");
    set_port(0, 1, 0, 4'd1, '0);
    set_port(1, 1, 0, 4'd0, '0);
    expect_grant(1, "R6 tie after A");
    serve(1, 1, 8'hA5, 0, 0, "R6 B read");
    expect_grant(0, "R5 held A");
    serve(0, 1, 8'h3C, 0, 0, "R6 A read");

    // R7 sweep: write all from alternating ports, read back from the other
    for (int i = 0; i < 16; i++) begin
      set_port(i[0], 1, 1, AW'(i), pat(i));
      expect_grant(i[0], "R2 sweep write");
      serve(i[0], 0, '0, 0, 0, "R7 sweep write");
    end
    for (int i = 0; i < 16; i++) begin
      set_port(!i[0], 1, 0, AW'(i), '0);
      expect_grant(!i[0], "R2 sweep read");
      serve(!i[0], 1, pat(i), 0, 0, "R7 sweep read");
    end

    // R5: B raised mid-service is served next and sees A's write
    set_port(1, 0, 0, 4'd7, '0);
    set_port(0, 1, 1, 4'd7, 8'h11);
    expect_grant(0, "R2 A write 7");
    serve(0, 0, '0, 2, 0, "R5 A write 7");
    expect_grant(1, "R5 B raised while busy");
    serve(1, 1, 8'h11, 0, 0, "R7 B read 7");

    // R8: B write raised and withdrawn during busy has no effect
    set_port(1, 0, 1, 4'd5, 8'hEE);
    set_port(0, 1, 1, 4'd3, 8'h77);
    expect_grant(0, "R2 A write 3");
    serve(0, 0, '0, 1, 2, "R8 withdraw window");
    #0.5;
    chk("R8 withdrawn not granted", int'(gnt_a | gnt_b), 0);
    @(negedge clk);
    #1;
    chk("R8 stays idle", int'(mem_busy), 0);
    set_port(0, 1, 0, 4'd5, '0);
    expect_grant(0, "R2 A read 5");
    serve(0, 1, pat(5), 0, 0, "R8 addr 5 unchanged");
    set_port(0, 1, 0, 4'd3, '0);
    expect_grant(0, "R2 A read 3");
    serve(0, 1, 8'h77, 0, 0, "R7 addr 3 written");

    finish_run();
  end

endmodule